// File: doc/BRIEF.md
# Used-Bit Replacement Translation Buffer

This block is a small, fully associative store of address translations. Each slot holds a tag made of a virtual page number, a partition identifier, a context identifier and a flag that marks the address as real rather than virtual. Each slot also holds a physical page number and an attribute field. A lookup port compares a request key against every slot in the same cycle. The result, with the physical page, the attributes and the slot index, appears on registered outputs on the following clock edge. An insert port writes a new translation that a walker supplies.

Slot reuse follows a one-bit-per-slot pseudo-LRU scheme. Each slot carries a "recently touched" bit, and a running count tracks how many of these bits are set. Inserting a translation or hitting on it sets the slot's bit. When every bit would be set, the scheme clears all of them except the bit of the slot just touched.

On an insert, the block first drops any slot that already holds the same tag, so a tag is never held twice. A synchronous flush empties the whole store.

Top module: `tlb_ub`

## Requirements
- R1: A lookup hits only when a valid slot matches on all four parts of the key: the virtual page number (address bits from PAGE_SHIFT upward, default bit 13 and above), the partition identifier, the context identifier and the real flag. Address bits below PAGE_SHIFT are ignored.
- R2: A lookup request in cycle t produces `rsp_valid`=1 in cycle t+1. In that cycle, `rsp_hit`, `rsp_idx`, `rsp_ppn` and `rsp_attr` reflect the slot matched in cycle t.
- R3: An insert writes into the lowest-index slot that is invalid or has its touched bit clear. If no slot qualifies, slot 0 is used.
- R4: An insert whose tag equals the tag of a valid slot invalidates that slot first. After the insert, the tag is held exactly once, with the new data.
- R5: An insert sets the touched bit of the written slot. A lookup hit sets the touched bit of the hit slot.
- R6: When the number of set touched bits reaches the slot count after an insert or a hit, every touched bit is cleared except the one for that slot, and the count becomes 1.
- R7: A lookup miss changes no touched bit and no slot.
- R8: When insert and lookup are requested in the same cycle, the insert is performed and the lookup reports `rsp_valid`=1 with `rsp_hit`=0.
- R9: `flush` invalidates every slot, clears every touched bit and resets the count. It takes precedence over an insert or a lookup in the same cycle. A lookup in that cycle reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the whole store |
| ins_en | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new translation |
| ins_pid | input | PID_W | Partition identifier of the new translation |
| ins_cid | input | CID_W | Context identifier of the new translation |
| ins_real | input | 1 | Real-address flag of the new translation |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_attr | input | ATTR_W | Attributes to store |
| lkp_en | input | 1 | Lookup request |
| lkp_va | input | VA_W | Virtual address to translate |
| lkp_pid | input | PID_W | Partition identifier of the request |
| lkp_cid | input | CID_W | Context identifier of the request |
| lkp_real | input | 1 | Real-address flag of the request |
| rsp_valid | output | 1 | A lookup response is present |
| rsp_hit | output | 1 | The lookup matched a slot |
| rsp_idx | output | $clog2(ENTRIES) | Index of the matched slot |
| rsp_ppn | output | PPN_W | Physical page number of the matched slot |
| rsp_attr | output | ATTR_W | Attributes of the matched slot |

## Verification
The bench uses four slots and a key space of 32 tags, so the store thrashes constantly. In a directed phase, each field of a stored key is flipped one at a time, which separates a true four-part comparison from a partial one. The page offset is varied at the same time, which shows that the low address bits are left out of the compare. A fixed sequence of inserts and hits is run with hand-computed slot indices. This sequence distinguishes lowest-free victim choice from round-robin, shows the saturation clear taking effect, and shows a re-inserted tag landing in a new slot while its old copy disappears. A long pseudo-random mix of inserts, lookups, same-cycle collisions and flushes is then checked against a reference model written from the requirements. Any divergence in touched-bit bookkeeping shows up as a wrong slot index or a wrong hit.

// File: rtl/tlb_ub_pkg.sv
package tlb_ub_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_FLUSH  = 2'd1,
    OP_INSERT = 2'd2,
    OP_LOOKUP = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/tlb_ub_match.sv
module tlb_ub_match #(
  parameter int N     = 8,
  parameter int TAG_W = 16
) (
  input  logic [TAG_W-1:0] tags  [N],
  input  logic [N-1:0]     valid,
  input  logic [TAG_W-1:0] key,
  output logic [N-1:0]     match
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_ub_prienc.sv
module tlb_ub_prienc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_ub_used.sv
module tlb_ub_used
  import tlb_ub_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  tlb_op_e       op,
  input  logic [IW-1:0] ins_idx,
  input  logic [N-1:0]  conflict,
  input  logic          hit,
  input  logic [IW-1:0] hit_idx,
  output logic [N-1:0]  used_q,
  output logic [CW-1:0] cnt_q
);
  logic [N-1:0]  used_n;
  logic [CW-1:0] cnt_n;
  logic          touch;
  logic [IW-1:0] touch_idx;

  always_comb begin
    used_n    = used_q;
    cnt_n     = cnt_q;
    touch     = 1'b0;
    touch_idx = '0;
    unique case (op)
      OP_FLUSH: begin
        used_n = '0;
        cnt_n  = '0;
      end
      OP_INSERT: begin
        for (int i = 0; i < N; i++) begin
          if (conflict[i] && used_n[i]) begin
            used_n[i] = 1'b0;
            cnt_n     = cnt_n - 1'b1;
          end
        end
        touch     = 1'b1;
        touch_idx = ins_idx;
      end
      OP_LOOKUP: begin
        touch     = hit;
        touch_idx = hit_idx;
      end
      default: ;
    endcase
    if (touch && !used_n[touch_idx]) begin
      used_n[touch_idx] = 1'b1;
      cnt_n             = cnt_n + 1'b1;
    end
    if (touch && (cnt_n == CW'(N))) begin
      used_n            = '0;
      used_n[touch_idx] = 1'b1;
      cnt_n             = CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      cnt_q  <= '0;
    end else begin
      used_q <= used_n;
      cnt_q  <= cnt_n;
    end
  end
endmodule

// File: rtl/tlb_ub.sv
module tlb_ub
  import tlb_ub_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 8,
  parameter int CID_W      = 13,
  parameter int PPN_W      = 20,
  parameter int ATTR_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       ins_en,
  input  logic [VA_W-1:0]            ins_va,
  input  logic [PID_W-1:0]           ins_pid,
  input  logic [CID_W-1:0]           ins_cid,
  input  logic                       ins_real,
  input  logic [PPN_W-1:0]           ins_ppn,
  input  logic [ATTR_W-1:0]          ins_attr,
  input  logic                       lkp_en,
  input  logic [VA_W-1:0]            lkp_va,
  input  logic [PID_W-1:0]           lkp_pid,
  input  logic [CID_W-1:0]           lkp_cid,
  input  logic                       lkp_real,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic [$clog2(ENTRIES)-1:0] rsp_idx,
  output logic [PPN_W-1:0]           rsp_ppn,
  output logic [ATTR_W-1:0]          rsp_attr
);
  localparam int IW     = $clog2(ENTRIES);
  localparam int CW     = $clog2(ENTRIES + 1);
  localparam int VPN_W  = VA_W - PAGE_SHIFT;
  localparam int TAG_W  = VPN_W + PID_W + CID_W + 1;
  localparam int DATA_W = PPN_W + ATTR_W;

  tlb_op_e             op;
  logic [TAG_W-1:0]    tag_q [ENTRIES];
  logic [ENTRIES-1:0]  valid_q;
  logic [ENTRIES-1:0]  used_q;
  logic [CW-1:0]       cnt_q;
  logic [DATA_W-1:0]   data_mem [ENTRIES];
  logic [TAG_W-1:0]    ins_tag;
  logic [TAG_W-1:0]    lkp_tag;
  logic [ENTRIES-1:0]  conflict;
  logic [ENTRIES-1:0]  lkp_match;
  logic [ENTRIES-1:0]  free_vec;
  logic                free_found;
  logic [IW-1:0]       free_idx;
  logic [IW-1:0]       victim;
  logic                hit_any;
  logic [IW-1:0]       hit_idx;
  logic [ENTRIES-1:0]  victim_oh;
  logic [DATA_W-1:0]   rd_q;

  assign ins_tag = {ins_va[VA_W-1:PAGE_SHIFT], ins_pid, ins_cid, ins_real};
  assign lkp_tag = {lkp_va[VA_W-1:PAGE_SHIFT], lkp_pid, lkp_cid, lkp_real};

  always_comb begin
    if (flush)       op = OP_FLUSH;
    else if (ins_en) op = OP_INSERT;
    else if (lkp_en) op = OP_LOOKUP;
    else             op = OP_IDLE;
  end

  tlb_ub_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_ins_match (
    .tags(tag_q), .valid(valid_q), .key(ins_tag), .match(conflict)
  );

  tlb_ub_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lkp_match (
    .tags(tag_q), .valid(valid_q), .key(lkp_tag), .match(lkp_match)
  );

  assign free_vec = ~valid_q | ~used_q;

  tlb_ub_prienc #(.N(ENTRIES), .IW(IW)) u_victim (
    .req(free_vec), .found(free_found), .idx(free_idx)
  );

  assign victim = free_found ? free_idx : '0;

  tlb_ub_prienc #(.N(ENTRIES), .IW(IW)) u_hitenc (
    .req(lkp_match), .found(hit_any), .idx(hit_idx)
  );

  tlb_ub_used #(.N(ENTRIES), .IW(IW), .CW(CW)) u_used (
    .clk(clk), .rst(rst), .op(op), .ins_idx(victim), .conflict(conflict),
    .hit(hit_any), .hit_idx(hit_idx), .used_q(used_q), .cnt_q(cnt_q)
  );

  always_comb begin
    victim_oh         = '0;
    victim_oh[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (op == OP_FLUSH) begin
      valid_q <= '0;
    end else if (op == OP_INSERT) begin
      valid_q <= (valid_q & ~conflict) | victim_oh;
    end
  end

  always_ff @(posedge clk) begin
    if (op == OP_INSERT) begin
      tag_q[victim]    <= ins_tag;
      data_mem[victim] <= {ins_ppn, ins_attr};
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= data_mem[hit_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= lkp_en;
      rsp_hit   <= (op == OP_LOOKUP) && hit_any;
      rsp_idx   <= hit_idx;
    end
  end

  assign rsp_ppn  = rd_q[DATA_W-1:ATTR_W];
  assign rsp_attr = rd_q[ATTR_W-1:0];
endmodule

// File: rtl/tlb_ub_chk.sv
module tlb_ub_chk #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          ins_en,
  input logic          lkp_en,
  input logic [N-1:0]  valid_q,
  input logic [N-1:0]  used_q,
  input logic [CW-1:0] cnt_q,
  input logic [N-1:0]  conflict,
  input logic          rsp_valid,
  input logic          rsp_hit
);
  AST_CNT_TRACKS_BITS: assert property (@(posedge clk) disable iff (rst)
    32'(cnt_q) == $countones(used_q)); // R6

  AST_USED_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (used_q & ~valid_q) == '0); // R5

  AST_TAG_HELD_ONCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(conflict)); // R4

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lkp_en |=> rsp_valid); // R2

  AST_HIT_HAS_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid); // R2

  AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (rst)
    (ins_en && lkp_en) |=> !rsp_hit); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0 && cnt_q == '0 && !rsp_hit)); // R9
endmodule

bind tlb_ub tlb_ub_chk #(.N(ENTRIES), .CW($clog2(ENTRIES + 1))) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .ins_en(ins_en), .lkp_en(lkp_en),
  .valid_q(valid_q), .used_q(used_q), .cnt_q(cnt_q), .conflict(conflict),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit)
);

// File: tb/tlb_ub_tb_top.sv
module tlb_ub_tb_top;
  localparam int N      = 4;
  localparam int VA_W   = 20;
  localparam int PSH    = 13;
  localparam int PID_W  = 2;
  localparam int CID_W  = 3;
  localparam int PPN_W  = 8;
  localparam int ATTR_W = 4;
  localparam int IW     = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0, ins_en = 1'b0, lkp_en = 1'b0;
  logic [VA_W-1:0] ins_va = '0, lkp_va = '0;
  logic [PID_W-1:0] ins_pid = '0, lkp_pid = '0;
  logic [CID_W-1:0] ins_cid = '0, lkp_cid = '0;
  logic ins_real = 1'b0, lkp_real = 1'b0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [ATTR_W-1:0] ins_attr = '0;
  logic rsp_valid, rsp_hit;
  logic [IW-1:0] rsp_idx;
  logic [PPN_W-1:0] rsp_ppn;
  logic [ATTR_W-1:0] rsp_attr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit m_v [N];
  bit m_u [N];
  int m_tag [N];
  int m_ppn [N];
  int m_attr [N];
  int m_cnt;

  always #2 clk = ~clk;

  tlb_ub #(.ENTRIES(N), .VA_W(VA_W), .PAGE_SHIFT(PSH), .PID_W(PID_W),
           .CID_W(CID_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .ins_en(ins_en), .ins_va(ins_va),
    .ins_pid(ins_pid), .ins_cid(ins_cid), .ins_real(ins_real),
    .ins_ppn(ins_ppn), .ins_attr(ins_attr), .lkp_en(lkp_en), .lkp_va(lkp_va),
    .lkp_pid(lkp_pid), .lkp_cid(lkp_cid), .lkp_real(lkp_real),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr)
  );

  function automatic int key_of(int vpn, int pid, int cid, int r);
    return ((vpn * 4 + pid) * 8 + cid) * 2 + r;
  endfunction

  function automatic void m_touch(int i);
    if (!m_u[i]) begin m_u[i] = 1'b1; m_cnt++; end
    if (m_cnt == N) begin
      for (int j = 0; j < N; j++) m_u[j] = 1'b0;
      m_u[i] = 1'b1;
      m_cnt = 1;
    end
  endfunction

  function automatic void m_clear();
    for (int j = 0; j < N; j++) begin m_v[j] = 1'b0; m_u[j] = 1'b0; end
    m_cnt = 0;
  endfunction

  function automatic int m_insert(int k, int ppn, int attr);
    int vic = 0;
    for (int j = N - 1; j >= 0; j--) if (!m_v[j] || !m_u[j]) vic = j;
    for (int j = 0; j < N; j++)
      if (m_v[j] && m_tag[j] == k) begin
        m_v[j] = 1'b0;
        if (m_u[j]) begin m_u[j] = 1'b0; m_cnt--; end
      end
    m_v[vic] = 1'b1; m_tag[vic] = k; m_ppn[vic] = ppn; m_attr[vic] = attr;
    m_touch(vic);
    return vic;
  endfunction

  function automatic int m_lookup(int k);
    for (int j = 0; j < N; j++)
      if (m_v[j] && m_tag[j] == k) begin m_touch(j); return j; end
    return -1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_insert(int vpn, int pid, int cid, int r, int off, int ppn, int attr);
    int vic;
    @(negedge clk);
    ins_en = 1'b1;
    ins_va = VA_W'((vpn << PSH) | off);
    ins_pid = PID_W'(pid); ins_cid = CID_W'(cid); ins_real = r[0];
    ins_ppn = PPN_W'(ppn); ins_attr = ATTR_W'(attr);
    @(negedge clk);
    ins_en = 1'b0;
    vic = m_insert(key_of(vpn, pid, cid, r), ppn, attr);
  endtask

  // returns model index (-1 on miss) and checks the response against the model
  task automatic do_lookup(string req, int vpn, int pid, int cid, int r, int off, output int idx);
    @(negedge clk);
    lkp_en = 1'b1;
    lkp_va = VA_W'((vpn << PSH) | off);
    lkp_pid = PID_W'(pid); lkp_cid = CID_W'(cid); lkp_real = r[0];
    @(negedge clk);
    lkp_en = 1'b0;
    idx = m_lookup(key_of(vpn, pid, cid, r));
    chk(req, "rsp_valid", int'(rsp_valid), 1);
    chk(req, "rsp_hit", int'(rsp_hit), (idx >= 0) ? 1 : 0);
    if (idx >= 0 && rsp_hit) begin
      chk(req, "rsp_idx", int'(rsp_idx), idx);
      chk(req, "rsp_ppn", int'(rsp_ppn), m_ppn[idx]);
      chk(req, "rsp_attr", int'(rsp_attr), m_attr[idx]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int ix;
    int lfsr;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R2", "reset rsp_valid", int'(rsp_valid), 0);
    chk("R2", "reset rsp_hit", int'(rsp_hit), 0);

    // R1: single-field mismatches miss, offset ignored
    do_insert(5, 2, 3, 1, 12, 8'hA5, 4'h6);
    do_lookup("R1", 5, 2, 3, 1, 8000, ix); chk("R1", "offset-ignored idx", ix, 0);
    do_lookup("R1", 4, 2, 3, 1, 12, ix);   chk("R1", "vpn mismatch", ix, -1);
    do_lookup("R1", 5, 1, 3, 1, 12, ix);   chk("R1", "pid mismatch", ix, -1);
    do_lookup("R1", 5, 2, 2, 1, 12, ix);   chk("R1", "cid mismatch", ix, -1);
    do_lookup("R1", 5, 2, 3, 0, 12, ix);   chk("R1", "real mismatch", ix, -1);

    // R9: flush empties the store
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0; m_clear();
    do_lookup("R9", 5, 2, 3, 1, 0, ix); chk("R9", "after flush", ix, -1);

    // R3/R5/R6 directed: A,B,C,D,E,F,G
    do_insert(1, 0, 0, 0, 0, 11, 1);
    do_insert(2, 0, 0, 0, 0, 12, 2);
    do_insert(3, 0, 0, 0, 0, 13, 3);
    do_lookup("R3", 1, 0, 0, 0, 0, ix); chk("R3", "A slot", ix, 0);
    do_insert(4, 0, 0, 0, 0, 14, 4);
    do_lookup("R3", 4, 0, 0, 0, 0, ix); chk("R3", "D slot", ix, 3);
    do_insert(6, 0, 0, 0, 0, 16, 5);
    do_lookup("R6", 6, 0, 0, 0, 0, ix); chk("R6", "E after saturation", ix, 0);
    do_lookup("R5", 2, 0, 0, 0, 0, ix); chk("R5", "B hit", ix, 1);
    do_insert(7, 0, 0, 0, 0, 17, 6);
    do_lookup("R3", 7, 0, 0, 0, 0, ix); chk("R3", "F slot", ix, 2);
    do_lookup("R7", 3, 0, 0, 0, 0, ix); chk("R7", "C evicted miss", ix, -1);
    do_insert(8, 0, 0, 0, 0, 18, 7);
    do_lookup("R7", 8, 0, 0, 0, 0, ix); chk("R7", "G slot after miss", ix, 0);
    // R4: re-insert G with new data
    do_insert(8, 0, 0, 0, 0, 99, 9);
    do_lookup("R4", 8, 0, 0, 0, 0, ix); chk("R4", "G moved", ix, 1);
    chk("R4", "G new ppn", int'(rsp_ppn), 99);

    // R8: collision
    @(negedge clk);
    ins_en = 1'b1; lkp_en = 1'b1;
    ins_va = VA_W'(9 << PSH); ins_pid = '0; ins_cid = '0; ins_real = 1'b0;
    ins_ppn = 8'd77; ins_attr = 4'd3;
    lkp_va = VA_W'(8 << PSH); lkp_pid = '0; lkp_cid = '0; lkp_real = 1'b0;
    @(negedge clk);
    ins_en = 1'b0; lkp_en = 1'b0;
    ix = m_insert(key_of(9, 0, 0, 0), 77, 3);
    chk("R8", "collide rsp_valid", int'(rsp_valid), 1);
    chk("R8", "collide rsp_hit", int'(rsp_hit), 0);
    do_lookup("R8", 9, 0, 0, 0, 0, ix); chk("R8", "insert performed", ix >= 0 ? 1 : 0, 1);

    // pseudo-random sweep against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      int vpn, pid, cid, r, sel;
      lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      vpn = (lfsr >> 1) & 3; pid = (lfsr >> 3) & 1; cid = (lfsr >> 4) & 1; r = (lfsr >> 5) & 1;
      sel = (lfsr >> 8) & 63;
      if (sel == 0) begin
        @(negedge clk); flush = 1'b1; lkp_en = 1'b1;
        lkp_va = VA_W'(vpn << PSH); lkp_pid = PID_W'(pid); lkp_cid = CID_W'(cid); lkp_real = r[0];
        @(negedge clk); flush = 1'b0; lkp_en = 1'b0; m_clear();
        chk("R9", "flush+lookup miss", int'(rsp_hit), 0);
      end else if (sel < 26) begin
        do_insert(vpn, pid, cid, r, (lfsr >> 6) & 511, (lfsr >> 7) & 255, lfsr & 15);
      end else begin
        do_lookup("R3/R5/R6", vpn, pid, cid, r, (lfsr >> 3) & 4095, ix);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule